// File: doc/BRIEF.md
# Alignment FIFO Threshold Monitor

This block keeps watch over the fill levels of several receive-side alignment FIFOs, one per channel, and compares each of them against a single lower and upper bound. The same pair of bounds applies to every channel at once. It comes from two 5-bit configuration fields. A channel counts as out of range when its fill level is strictly below the lower bound or strictly above the upper bound.

When a channel moves from in range to out of range, the block raises a one-cycle event for that channel. At the same moment it sets a sticky per-channel flag. The flag holds until software writes a one to that channel's clear strobe. A single interrupt line is high while any flag is set. Configuration software normally programs the lower bound within 0..23 and the upper bound within 0..22; typical settings are 2 and 21. The comparison treats whatever values it is given literally.

Top module: `afm_monitor`

## Requirements
- R1: A channel is out of range when its fill level is strictly less than `thr_lo_i`. A fill level equal to `thr_lo_i` is in range.
- R2: A channel is out of range when its fill level is strictly greater than `thr_hi_i`. A fill level equal to `thr_hi_i` is in range.
- R3: Bit n of `thr_evt_o` is high for exactly one cycle, in the cycle after the clock edge that first samples channel n out of range following an in-range sample (or reset). It stays low while the violation persists. It fires again after the channel has returned to range and then left it again.
- R4: Bit n of `thr_flag_o` goes high in the same cycle as bit n of `thr_evt_o`. It stays high until it is cleared.
- R5: If a new event and a clear strobe for the same channel are sampled at the same edge, the flag stays high.
- R6: A clear strobe on bit n of `flag_clr_i` (1 = clear) with no new event drops flag n at the next edge. It leaves the flags of the other channels unchanged.
- R7: `irq_o` is high exactly when at least one bit of `thr_flag_o` is high.
- R8: While `rst_n` is low, all events, flags and `irq_o` are zero.
- R9: A change of either threshold is applied to all channels at once. A change that moves in-range channels out of range raises events on each of them at the same edge.
- R10: Channels are independent: a violation or clear on one channel leaves the event and flag bits of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_lvl_i | input | NUM_CH*LVL_W (20) | Fill levels, channel n in bits [n*LVL_W +: LVL_W] |
| thr_lo_i | input | THR_W (5) | Shared lower bound |
| thr_hi_i | input | THR_W (5) | Shared upper bound |
| flag_clr_i | input | NUM_CH (4) | Write-one-to-clear strobe per channel |
| thr_evt_o | output | NUM_CH (4) | One-cycle threshold event per channel |
| thr_flag_o | output | NUM_CH (4) | Sticky threshold flag per channel |
| irq_o | output | 1 | OR of all sticky flags |

## Verification
The assertions check several rules on every cycle: an event never lasts two cycles, an event always follows an out-of-range sample, a flag is set whenever its event fires, and a flag holds, clears or survives a clear race as the strobe dictates. They also tie rises and falls of the interrupt to events and clears. Only the bench scenarios can show the exact boundary behaviour at fill levels equal to each bound. They also show that a threshold change raises events on every channel together, and that a clear on one channel leaves the others untouched.

// File: rtl/afm_pkg.sv
package afm_pkg;

  // Out-of-range test for one channel: strictly below lo or strictly above hi.
  function automatic logic lvl_outside(input logic [7:0] lvl,
                                       input logic [7:0] lo,
                                       input logic [7:0] hi);
    logic below;
    logic above;
    below = (lvl < lo);
    above = (lvl > hi);
    return below | above;
  endfunction

  // New event: out of range now, in range at the previous sample.
  function automatic logic entry_edge(input logic now_out, input logic was_out);
    return now_out & ~was_out;
  endfunction

  // Next sticky-flag state: a set wins over a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/afm_chan_cmp.sv
module afm_chan_cmp #(
  parameter int LVL_W = 5,
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [THR_W-1:0] thr_hi,
  output logic             out_now,
  output logic             rise,
  output logic             evt
);
  import afm_pkg::*;

  localparam int PADL = 8 - LVL_W;
  localparam int PADT = 8 - THR_W;

  logic was_out_q;

  always_comb begin
    out_now = lvl_outside({{PADL{1'b0}}, fill_lvl},
                          {{PADT{1'b0}}, thr_lo},
                          {{PADT{1'b0}}, thr_hi});
    rise    = entry_edge(out_now, was_out_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_out_q <= 1'b0;
      evt       <= 1'b0;
    end else begin
      was_out_q <= out_now;
      evt       <= rise;
    end
  end

  // R3: an event lasts a single cycle
  p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R3: an event follows an out-of-range sample
  p_evt_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(out_now));

endmodule

// File: rtl/afm_flag.sv
module afm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  import afm_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set, clr);
  end

  // R4: set forces the flag high next cycle
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R4: without a clear the flag holds
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R5: clear racing a set leaves the flag high
  p_flag_race_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set) |=> flag);
  // R6: clear without a set drops the flag
  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

endmodule

// File: rtl/afm_monitor.sv
module afm_monitor #(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 5,
  parameter int THR_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*LVL_W-1:0] fill_lvl_i,
  input  logic [THR_W-1:0]        thr_lo_i,
  input  logic [THR_W-1:0]        thr_hi_i,
  input  logic [NUM_CH-1:0]       flag_clr_i,
  output logic [NUM_CH-1:0]       thr_evt_o,
  output logic [NUM_CH-1:0]       thr_flag_o,
  output logic                    irq_o
);

  logic [NUM_CH-1:0] out_now_w;
  logic [NUM_CH-1:0] rise_w;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    afm_chan_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_lvl (fill_lvl_i[g*LVL_W +: LVL_W]),
      .thr_lo   (thr_lo_i),
      .thr_hi   (thr_hi_i),
      .out_now  (out_now_w[g]),
      .rise     (rise_w[g]),
      .evt      (thr_evt_o[g])
    );

    afm_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (rise_w[g]),
      .clr   (flag_clr_i[g]),
      .flag  (thr_flag_o[g])
    );
  end

  assign irq_o = |thr_flag_o;

  // R7: the interrupt only rises together with an event
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (thr_evt_o != '0));
  // R6: the interrupt only falls after a clear strobe
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(flag_clr_i) != '0));

endmodule

// File: tb/tb_afm_monitor.sv
module tb_afm_monitor;
  localparam int NC = 4;
  localparam int LW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC*LW-1:0] fill_lvl_i = '0;
  logic [4:0]      thr_lo_i = 5'd2;
  logic [4:0]      thr_hi_i = 5'd21;
  logic [NC-1:0]   flag_clr_i = '0;
  logic [NC-1:0]   thr_evt_o;
  logic [NC-1:0]   thr_flag_o;
  logic            irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  afm_monitor dut (
    .clk(clk), .rst_n(rst_n), .fill_lvl_i(fill_lvl_i),
    .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i), .flag_clr_i(flag_clr_i),
    .thr_evt_o(thr_evt_o), .thr_flag_o(thr_flag_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_fill(input int ch, input int v);
    fill_lvl_i[ch*LW +: LW] = v[LW-1:0];
  endtask

  task automatic all_fill(input int v);
    for (int c = 0; c < NC; c++) set_fill(c, v);
  endtask

  task automatic clear_all();
    all_fill(10);
    flag_clr_i = '1;
    tick();
    flag_clr_i = '0;
    tick();
  endtask

  task automatic t_reset();
    all_fill(10);
    rst_n = 1'b0;
    tick(); tick();
    check("R8 evt", thr_evt_o, 0);
    check("R8 flag", thr_flag_o, 0);
    check("R8 irq", irq_o, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_low();
    set_fill(0, 2); tick();
    check("R1 equal-min evt", thr_evt_o, 0);
    set_fill(0, 1); tick();
    check("R1 below-min evt", thr_evt_o, 4'b0001);
    check("R4 flag with evt", thr_flag_o, 4'b0001);
    check("R7 irq", irq_o, 1);
    tick();
    check("R3 persistent no retrigger", thr_evt_o, 0);
    check("R4 flag holds", thr_flag_o, 4'b0001);
  endtask

  task automatic t_clear();
    set_fill(0, 10); tick();
    check("R4 flag holds after return", thr_flag_o, 4'b0001);
    flag_clr_i = 4'b0001; tick(); flag_clr_i = '0;
    check("R6 flag cleared", thr_flag_o, 0);
    check("R7 irq low", irq_o, 0);
  endtask

  task automatic t_high();
    set_fill(2, 21); tick();
    check("R2 equal-max evt", thr_evt_o, 0);
    set_fill(2, 22); tick();
    check("R2 above-max evt", thr_evt_o, 4'b0100);
    set_fill(2, 10);
    flag_clr_i = 4'b0010; tick(); flag_clr_i = '0;
    check("R6 other-channel clear", thr_flag_o, 4'b0100);
    clear_all();
    check("R6 all cleared", thr_flag_o, 0);
  endtask

  task automatic t_race();
    set_fill(3, 30); tick();
    check("R10 ch3 only", thr_evt_o, 4'b1000);
    set_fill(3, 10); tick();
    set_fill(3, 31); flag_clr_i = 4'b1000; tick(); flag_clr_i = '0;
    check("R5 race evt", thr_evt_o, 4'b1000);
    check("R5 race flag stays", thr_flag_o, 4'b1000);
    clear_all();
  endtask

  task automatic t_retrigger();
    set_fill(1, 0); tick();
    check("R3 first evt", thr_evt_o, 4'b0010);
    set_fill(1, 10); tick();
    check("R3 no evt on return", thr_evt_o, 0);
    set_fill(1, 0); tick();
    check("R3 re-fire", thr_evt_o, 4'b0010);
    clear_all();
  endtask

  task automatic t_shared();
    all_fill(10);
    thr_lo_i = 5'd12; tick();
    check("R9 all channels on lo change", thr_evt_o, 4'b1111);
    check("R9 all flags", thr_flag_o, 4'b1111);
    thr_lo_i = 5'd2; tick();
    thr_hi_i = 5'd9; tick();
    check("R9 all channels on hi change", thr_evt_o, 4'b1111);
    thr_hi_i = 5'd21;
    flag_clr_i = 4'b0101; tick(); flag_clr_i = '0;
    check("R10 partial clear", thr_flag_o, 4'b1010);
    check("R7 irq with partial flags", irq_o, 1);
    clear_all();
    check("R7 irq low at end", irq_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_low();
    t_clear();
    t_high();
    t_race();
    t_retrigger();
    t_shared();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule